// File: doc/BRIEF.md
# Permuted 3D Element Index Generator

This block turns the linear step count of a vector element loop into a physical element index. A 32-bit shape word describes a box of up to three dimensions, a 3-bit base offset, and a code that sets how the three nested loops are ordered. Each accepted step request produces one index. After each index the block advances an internal three-axis counter. The code chooses which axis changes fastest and the order in which carries move to the other two axes.

A start strobe loads a new shape and restarts the walk from step zero. A load strobe also loads a shape, and then restores the counters to a saved step number, so a loop broken by a trap can resume. It restores by stepping internally from zero, one step per clock, and holds busy high until it reaches the saved step. Two error conditions are flagged: an illegal nesting code, and an index that lands outside the register file.

Top module: `elem_remap_gen`

## Requirements
- R1: The shape word holds each dimension size minus one in a 7-bit field: x in bits 6..0, y in bits 14..8, z in bits 22..16. A field value of v gives v+1 elements on that axis.
- R2: The base offset is 3 bits: offset bit 0 is shape bit 7, offset bit 1 is shape bit 15 and offset bit 2 is shape bit 23. The offset is added to every remapped index.
- R3: For counter values (x, y, z) the index is offset + x + y*X + z*X*Y, where X and Y are the true x and y sizes.
- R4: The nesting code in bits 26..24 picks the axis order, listed fastest first. Code 0 gives x,y,z. Code 1 gives x,z,y. Code 2 gives y,x,z. Code 3 gives y,z,x. Code 4 gives z,x,y. Code 5 gives z,y,x. When the fastest axis is at its limit it returns to zero and the next axis in the order advances.
- R5: Codes 6 and 7 set bad_perm_o from the next clock after start or load, for as long as that shape stays loaded. The walk then uses the x,y,z order.
- R6: An all-zero shape word turns remapping off, and the index equals the linear step number (0, 1, 2, ...). This is also the state after reset.
- R7: When the last axis in the order goes past its limit, all three counters return to zero and the index sequence repeats.
- R8: overrun_o is valid while idx_valid_o is high and is 1 exactly when idx_o >= RF_ELEMS (default 128).
- R9: After load_i with a saved step N, busy_o is high for exactly N cycles. The next step then gives the index of step N of the new shape. N = 0 gives no busy cycle.
- R10: A step request is taken only when busy_o is low and neither start_i nor load_i is high. The result appears on idx_o with idx_valid_o high in the next cycle. At most one index is produced per clock. Requests made while busy are ignored.
- R11: After reset, idx_valid_o, busy_o, bad_perm_o and overrun_o are all 0.
- R12: start_i restarts the walk at step 0 with the new shape. If load_i and start_i are high in the same cycle, load_i wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| shape_i | input | 32 | Shape word, captured on start_i or load_i |
| start_i | input | 1 | Capture the shape and restart at step 0 |
| load_i | input | 1 | Capture the shape and restore to load_step_i |
| load_step_i | input | 16 | Saved linear step to restore |
| step_i | input | 1 | Request the next index |
| idx_o | output | 22 | Physical element index |
| idx_valid_o | output | 1 | idx_o and overrun_o are valid |
| busy_o | output | 1 | A restore is in progress |
| bad_perm_o | output | 1 | The loaded nesting code is reserved |
| overrun_o | output | 1 | The index is past the register file |

## Verification
The bench walks all six nesting orders over boxes with unequal side lengths. A design with a swapped carry chain therefore gives a different sequence, not just a reordered copy of the same one. It steps past the last element to catch a counter that stalls or skips at the wrap. It also scatters the offset bits, so that a misplaced offset bit shows up as a wrong base. Restores are checked with step requests held high during busy, and with a saved step of zero. A controller that is off by one, or one that emits indices while restoring, gives a wrong busy length or a wrong first index. Overrun is probed one below and exactly at the register-file capacity, to catch a compare of > where >= is required.

// File: rtl/elem_remap_pkg.sv
package elem_remap_pkg;
  localparam int AXES = 3;

  typedef logic [1:0] axis_t;
  typedef axis_t [AXES-1:0] order_t;  // [0] is the fastest axis

  function automatic order_t perm_order(input logic [2:0] code);
    order_t o;
    case (code)
      3'd1:    o = {2'd1, 2'd2, 2'd0};
      3'd2:    o = {2'd2, 2'd0, 2'd1};
      3'd3:    o = {2'd0, 2'd2, 2'd1};
      3'd4:    o = {2'd1, 2'd0, 2'd2};
      3'd5:    o = {2'd0, 2'd1, 2'd2};
      default: o = {2'd2, 2'd1, 2'd0};
    endcase
    return o;
  endfunction

  function automatic logic perm_reserved(input logic [2:0] code);
    return code[2] & code[1];
  endfunction
endpackage

// File: rtl/remap_shape_reg.sv
module remap_shape_reg
  import elem_remap_pkg::*;
#(
  parameter int DIM_W   = 7,
  parameter int SHAPE_W = 32,
  localparam int FLD_W  = DIM_W + 1,
  localparam int XY_W   = 2 * FLD_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        latch_i,
  input  logic [SHAPE_W-1:0]          shape_i,
  output logic [AXES-1:0][DIM_W-1:0]  lim_o,
  output logic [FLD_W-1:0]            sz_x_o,
  output logic [XY_W-1:0]             sz_xy_o,
  output logic [AXES-1:0]             offs_o,
  output order_t                      order_o,
  output logic                        linear_o,
  output logic                        bad_perm_o
);
  localparam int PERM_LSB = AXES * FLD_W;

  logic [AXES-1:0][DIM_W-1:0] lim_d;
  logic [AXES-1:0]            offs_d;
  logic [FLD_W-1:0]           sz_x_d, sz_y_d;
  logic [2:0]                 code_d;

  for (genvar g = 0; g < AXES; g++) begin : g_fld
    assign lim_d[g]  = shape_i[g*FLD_W +: DIM_W];
    assign offs_d[g] = shape_i[g*FLD_W + DIM_W];
  end

  assign code_d = shape_i[PERM_LSB +: 3];
  assign sz_x_d = {1'b0, lim_d[0]} + 1'b1;
  assign sz_y_d = {1'b0, lim_d[1]} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_o      <= '0;
      sz_x_o     <= FLD_W'(1);
      sz_xy_o    <= XY_W'(1);
      offs_o     <= '0;
      order_o    <= perm_order(3'd0);
      linear_o   <= 1'b1;
      bad_perm_o <= 1'b0;
    end else if (latch_i) begin
      lim_o      <= lim_d;
      sz_x_o     <= sz_x_d;
      sz_xy_o    <= XY_W'(sz_x_d) * XY_W'(sz_y_d);
      offs_o     <= offs_d;
      order_o    <= perm_order(code_d);
      linear_o   <= (shape_i == '0);
      bad_perm_o <= perm_reserved(code_d);
    end
  end
endmodule

// File: rtl/remap_axis_ctr.sv
module remap_axis_ctr
  import elem_remap_pkg::*;
#(
  parameter int DIM_W = 7
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clear_i,
  input  logic                        adv_i,
  input  logic [AXES-1:0][DIM_W-1:0]  lim_i,
  input  order_t                      order_i,
  output logic [AXES-1:0][DIM_W-1:0]  cnt_o
);
  logic [AXES-1:0][DIM_W-1:0] cnt_q, cnt_d;
  logic [AXES-1:0] at_lim, inc, carry;

  always_comb begin
    for (int a = 0; a < AXES; a++) at_lim[a] = (cnt_q[a] == lim_i[a]);
    // carry[p]: every faster axis in the order sits at its limit
    carry[0] = 1'b1;
    for (int p = 0; p < AXES - 1; p++) carry[p+1] = carry[p] & at_lim[order_i[p]];
    inc = '0;
    for (int p = 0; p < AXES; p++) inc[order_i[p]] = carry[p];
    for (int a = 0; a < AXES; a++) begin
      if (!inc[a])       cnt_d[a] = cnt_q[a];
      else if (at_lim[a]) cnt_d[a] = '0;
      else               cnt_d[a] = cnt_q[a] + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (adv_i)   cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  for (genvar g = 0; g < AXES; g++) begin : g_chk
    // R7
    cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(clear_i) |-> cnt_q[g] <= lim_i[g]);
  end

  // R4
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !adv_i) |=> $stable(cnt_q));
endmodule

// File: rtl/remap_index_calc.sv
module remap_index_calc
  import elem_remap_pkg::*;
#(
  parameter int DIM_W    = 7,
  parameter int STEP_W   = 16,
  parameter int IDX_W    = 22,
  parameter int RF_ELEMS = 128,
  localparam int FLD_W   = DIM_W + 1,
  localparam int XY_W    = 2 * FLD_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        fire_i,
  input  logic [AXES-1:0][DIM_W-1:0]  cnt_i,
  input  logic [FLD_W-1:0]            sz_x_i,
  input  logic [XY_W-1:0]             sz_xy_i,
  input  logic [AXES-1:0]             offs_i,
  input  logic                        linear_i,
  input  logic [STEP_W-1:0]           lin_step_i,
  output logic [IDX_W-1:0]            idx_o,
  output logic                        valid_o,
  output logic                        overrun_o
);
  logic [IDX_W-1:0] term_y, term_z, sum_d, idx_d;

  // one multiply level per term; sizes come from registers
  assign term_y = IDX_W'(cnt_i[1]) * IDX_W'(sz_x_i);
  assign term_z = IDX_W'(cnt_i[2]) * IDX_W'(sz_xy_i);
  assign sum_d  = IDX_W'(offs_i) + IDX_W'(cnt_i[0]) + term_y + term_z;
  assign idx_d  = linear_i ? IDX_W'(lin_step_i) : sum_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o     <= '0;
      valid_o   <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      valid_o <= fire_i;
      if (fire_i) begin
        idx_o     <= idx_d;
        overrun_o <= (idx_d >= IDX_W'(RF_ELEMS));
      end
    end
  end
endmodule

// File: rtl/elem_remap_gen.sv
module elem_remap_gen
  import elem_remap_pkg::*;
#(
  parameter int DIM_W    = 7,
  parameter int SHAPE_W  = 32,
  parameter int STEP_W   = 16,
  parameter int RF_ELEMS = 128,
  localparam int IDX_W   = (3 * DIM_W + 1 > STEP_W) ? 3 * DIM_W + 1 : STEP_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SHAPE_W-1:0] shape_i,
  input  logic               start_i,
  input  logic               load_i,
  input  logic [STEP_W-1:0]  load_step_i,
  input  logic               step_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               idx_valid_o,
  output logic               busy_o,
  output logic               bad_perm_o,
  output logic               overrun_o
);
  localparam int FLD_W    = DIM_W + 1;
  localparam int XY_W     = 2 * FLD_W;
  localparam int PERM_LSB = AXES * FLD_W;

  logic                       latch, fire, adv;
  logic [STEP_W-1:0]          step_q, target_q;
  logic                       restore_q;
  logic [AXES-1:0][DIM_W-1:0] lim, cnt;
  logic [FLD_W-1:0]           sz_x;
  logic [XY_W-1:0]            sz_xy;
  logic [AXES-1:0]            offs;
  order_t                     order;
  logic                       linear;

  assign latch = start_i | load_i;
  assign fire  = step_i & ~restore_q & ~latch;
  assign adv   = fire | restore_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q    <= '0;
      target_q  <= '0;
      restore_q <= 1'b0;
    end else if (load_i) begin
      step_q    <= '0;
      target_q  <= load_step_i;
      restore_q <= (load_step_i != '0);
    end else if (start_i) begin
      step_q    <= '0;
      target_q  <= '0;
      restore_q <= 1'b0;
    end else if (adv) begin
      step_q <= step_q + 1'b1;
      if (restore_q && (step_q + 1'b1 == target_q)) restore_q <= 1'b0;
    end
  end

  remap_shape_reg #(.DIM_W(DIM_W), .SHAPE_W(SHAPE_W)) u_shape (
    .clk_i, .rst_ni,
    .latch_i   (latch),
    .shape_i,
    .lim_o     (lim),
    .sz_x_o    (sz_x),
    .sz_xy_o   (sz_xy),
    .offs_o    (offs),
    .order_o   (order),
    .linear_o  (linear),
    .bad_perm_o
  );

  remap_axis_ctr #(.DIM_W(DIM_W)) u_ctr (
    .clk_i, .rst_ni,
    .clear_i (latch),
    .adv_i   (adv),
    .lim_i   (lim),
    .order_i (order),
    .cnt_o   (cnt)
  );

  remap_index_calc #(
    .DIM_W(DIM_W), .STEP_W(STEP_W), .IDX_W(IDX_W), .RF_ELEMS(RF_ELEMS)
  ) u_idx (
    .clk_i, .rst_ni,
    .fire_i     (fire),
    .cnt_i      (cnt),
    .sz_x_i     (sz_x),
    .sz_xy_i    (sz_xy),
    .offs_i     (offs),
    .linear_i   (linear),
    .lin_step_i (step_q),
    .idx_o,
    .valid_o    (idx_valid_o),
    .overrun_o
  );

  assign busy_o = restore_q;

  // R10
  valid_after_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_valid_o |-> $past(step_i && !busy_o && !start_i && !load_i));

  // R9
  busy_from_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(load_i));

  // R8
  overrun_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_valid_o |-> (overrun_o == (idx_o >= IDX_W'(RF_ELEMS))));

  // R5
  bad_perm_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(latch) |-> (bad_perm_o == ($past(shape_i[PERM_LSB+1 +: 2]) == 2'b11)));
endmodule

// File: tb/tb_elem_remap_gen.sv
module tb_elem_remap_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] shape = '0;
  logic        start = 1'b0, load = 1'b0, step = 1'b0;
  logic [15:0] load_step = '0;
  logic [21:0] idx;
  logic        idx_valid, busy, bad_perm, overrun;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  elem_remap_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .shape_i(shape), .start_i(start), .load_i(load),
    .load_step_i(load_step), .step_i(step), .idx_o(idx), .idx_valid_o(idx_valid),
    .busy_o(busy), .bad_perm_o(bad_perm), .overrun_o(overrun)
  );

  function automatic logic [31:0] mk(int x, int y, int z, int p, int o);
    logic [31:0] s = '0;
    s[6:0] = 7'(x); s[14:8] = 7'(y); s[22:16] = 7'(z); s[26:24] = 3'(p);
    s[7] = o[0]; s[15] = o[1]; s[23] = o[2];
    return s;
  endfunction

  function automatic int ref_idx(logic [31:0] s, int n);
    int lim[3]; int c[3]; int ord[3]; int off; int a;
    if (s == 0) return n;
    lim[0] = int'(s[6:0]); lim[1] = int'(s[14:8]); lim[2] = int'(s[22:16]);
    off = int'({s[23], s[15], s[7]});
    case (s[26:24])
      3'd1: ord = '{0, 2, 1};
      3'd2: ord = '{1, 0, 2};
      3'd3: ord = '{1, 2, 0};
      3'd4: ord = '{2, 0, 1};
      3'd5: ord = '{2, 1, 0};
      default: ord = '{0, 1, 2};
    endcase
    c = '{0, 0, 0};
    repeat (n) begin
      for (int i = 0; i < 3; i++) begin
        a = ord[i];
        if (c[a] == lim[a]) c[a] = 0;
        else begin c[a]++; break; end
      end
    end
    return off + c[0] + c[1] * (lim[0] + 1) + c[2] * (lim[0] + 1) * (lim[1] + 1);
  endfunction

  task automatic chk(int act, int exp, string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start(logic [31:0] s);
    @(negedge clk); shape = s; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic step_chk(int exp, string req);
    @(negedge clk); step = 1'b1;
    @(negedge clk); step = 1'b0;
    chk(int'(idx_valid), 1, req);
    chk(int'(idx), exp, req);
  endtask

  task automatic run_seq(logic [31:0] s, int n, string req);
    do_start(s);
    for (int k = 0; k < n; k++) step_chk(ref_idx(s, k), req);
  endtask

  task automatic do_load(logic [31:0] s, int n, bit poke, bit with_start, string req);
    int cnt = 0;
    @(negedge clk); shape = s; load = 1'b1; load_step = 16'(n); start = with_start;
    @(negedge clk); load = 1'b0; start = 1'b0; step = poke;
    while (busy && cnt < 1000) begin
      cnt++;
      if (idx_valid) chk(1, 0, {req, " valid during busy"});
      @(negedge clk);
    end
    step = 1'b0;
    chk(int'(idx_valid), 0, {req, " no index from ignored step"});
    chk(cnt, n, {req, " busy cycles"});
  endtask

  task automatic t_reset();
    chk(int'(idx_valid), 0, "R11 valid");
    chk(int'(busy), 0, "R11 busy");
    chk(int'(bad_perm), 0, "R11 bad_perm");
    chk(int'(overrun), 0, "R11 overrun");
  endtask

  task automatic t_linear();
    for (int k = 0; k < 4; k++) step_chk(k, "R6 linear after reset");
    run_seq(32'h0, 3, "R6 zero shape");
  endtask

  task automatic t_basic();
    run_seq(mk(2, 3, 1, 0, 0), 24 + 3, "R1 R3 R7 order 0 with wrap");
  endtask

  task automatic t_perms();
    for (int p = 1; p < 6; p++) run_seq(mk(2, 1, 2, p, 0), 18 + 2, "R4 permute");
  endtask

  task automatic t_offset();
    run_seq(mk(1, 2, 0, 2, 5), 7, "R2 offset 5");
    run_seq(mk(0, 0, 1, 0, 2), 3, "R2 offset 2");
  endtask

  task automatic t_bad_perm();
    do_start(mk(1, 1, 1, 6, 0));
    chk(int'(bad_perm), 1, "R5 code 6 flag");
    for (int k = 0; k < 9; k++) step_chk(ref_idx(mk(1, 1, 1, 0, 0), k), "R5 code 6 order");
    do_start(mk(1, 1, 1, 7, 0));
    chk(int'(bad_perm), 1, "R5 code 7 flag");
    do_start(mk(1, 1, 1, 5, 0));
    chk(int'(bad_perm), 0, "R5 legal clears flag");
  endtask

  task automatic t_restore();
    do_load(mk(2, 3, 1, 3, 1), 7, 1'b1, 1'b0, "R9 R10 restore 7");
    step_chk(ref_idx(mk(2, 3, 1, 3, 1), 7), "R9 index after restore");
    step_chk(ref_idx(mk(2, 3, 1, 3, 1), 8), "R9 continue");
    do_load(mk(2, 3, 1, 4, 0), 0, 1'b0, 1'b0, "R9 restore 0");
    step_chk(ref_idx(mk(2, 3, 1, 4, 0), 0), "R9 index after restore 0");
    do_load(32'h0, 5, 1'b0, 1'b0, "R9 linear restore");
    step_chk(5, "R6 R9 linear resume");
  endtask

  task automatic t_overrun();
    do_load(mk(15, 7, 0, 0, 1), 126, 1'b0, 1'b0, "R8 restore 126");
    step_chk(127, "R8 last legal");
    chk(int'(overrun), 0, "R8 below capacity");
    step_chk(128, "R8 at capacity");
    chk(int'(overrun), 1, "R8 at capacity flag");
  endtask

  task automatic t_start_prio();
    run_seq(mk(3, 2, 0, 0, 0), 5, "R12 pre");
    do_start(mk(3, 2, 0, 0, 0));
    step_chk(0, "R12 start restarts");
    do_load(mk(1, 2, 1, 2, 0), 2, 1'b0, 1'b1, "R12 load beats start");
    step_chk(ref_idx(mk(1, 2, 1, 2, 0), 2), "R12 load wins index");
    @(negedge clk);
    chk(int'(idx_valid), 0, "R10 no step no valid");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_linear();
    t_basic();
    t_perms();
    t_offset();
    t_bad_perm();
    t_restore();
    t_overrun();
    t_start_prio();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule